// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block generates the raster timing for a display panel: horizontal sync, vertical sync, a data-enable window and a dot-rate clock enable. The dot rate comes from the system clock through a programmable divider. All position counters advance only on that enable. The pixel and line position counters are also exposed, so a consumer can align pixel fetch with the raster and so a test can measure line and frame periods directly.

Two panel modes are supported, selected per frame. In TFT mode vertical sync spans a programmable number of whole lines from the start of the frame. The frame also has blank lines before and after the visible region. In STN mode there are no blank lines. Vertical sync then lasts exactly one line period and starts on the first visible dot of the frame.

All timing fields, including the mode, are copied into a shadow set when a frame starts. A host can therefore rewrite them at any time without tearing the current frame. The divider setting is not shadowed and acts at once.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `rst` is held, `pix_cnt` and `line_cnt` are 0 and `dot_ce` and `den` are low. `hsync` is high. `vsync` is high when `stn_mode` is 0 and low when `stn_mode` is 1.
- R2: `dot_ce` is a one-cycle pulse that repeats every `clk_div`+1 system clocks. The counters and the sync outputs change only on the clock edge that follows a cycle in which `dot_ce` is high.
- R3: A line lasts `hsync_width`+`hback`+`hactive`+`hfront`+2*`sync_delay`+5 dot ticks. `pix_cnt` counts 0 up to that length minus one, and it then returns to 0 as `line_cnt` advances.
- R4: `hsync` is high for dot positions 0 to `hsync_width` of every line, which is `hsync_width`+1 ticks.
- R5: `den` is high only on visible lines, for `hactive`+1 ticks starting at dot position `hsync_width`+`hback`+`sync_delay`+2. It is low at every other position.
- R6: In TFT mode a frame holds `vback`+`vactive`+1+`vfront` lines. The visible lines are `vback` to `vback`+`vactive`.
- R7: In TFT mode `vsync` is high on lines 0 to `vsync_width`. It rises together with dot 0 of line 0.
- R8: In STN mode `vback`, `vfront` and `vsync_width` have no effect. A frame holds `vactive`+1 lines, and all of them are visible.
- R9: In STN mode `vsync` rises on the first visible dot of line 0 and stays high for exactly one line period. It falls on the first visible dot of line 1.
- R10: The mode and timing fields are captured when a frame starts. A change made in the middle of a frame first shows in the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stn_mode | input | 1 | 1 selects STN vertical timing, 0 selects TFT |
| clk_div | input | DIV_W | Dot-rate divider; the dot tick period is clk_div+1 clocks |
| hsync_width | input | H_W | Horizontal sync width minus one, in dots |
| hback | input | H_W | Horizontal back porch minus one, in dots |
| hfront | input | H_W | Horizontal front porch term, in dots |
| sync_delay | input | H_W | Extra delay added to both horizontal porches |
| hactive | input | H_W | Visible dots per line minus one (1 or more) |
| vsync_width | input | V_W | TFT vertical sync width minus one, in lines |
| vback | input | V_W | TFT blank lines before the visible region |
| vfront | input | V_W | TFT blank lines after the visible region |
| vactive | input | V_W | Visible lines per frame minus one (1 or more) |
| dot_ce | output | 1 | Dot-rate clock enable pulse |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable, high on visible dots |
| pix_cnt | output | H_W+3 | Dot position within the current line |
| line_cnt | output | V_W+2 | Line position within the current frame |

## Verification
A wrong line or frame limit shows at the ports within one line or one frame. The visible symptom is a vsync-to-vsync distance that differs from the product of the line length and the line count. A stale or early shadow copy shows up at the first frame boundary after a mid-frame rewrite, because the period of the frame in progress would change. A misplaced decode shows on the very next dot tick as a sync or enable edge at the wrong `pix_cnt`. To catch it, every dot position is compared against a model built from the requirements. An off-by-one in the divider shows as a wrong spacing between two `dot_ce` pulses, or as a counter change in a cycle without an enable.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int H_W   = 10;
  localparam int V_W   = 10;
  localparam int PIX_W = H_W + 3;
  localparam int LIN_W = V_W + 2;

  typedef struct packed {
    logic           stn;
    logic [H_W-1:0] hpw;
    logic [H_W-1:0] hbp;
    logic [H_W-1:0] hfp;
    logic [H_W-1:0] dly;
    logic [H_W-1:0] hact;
    logic [V_W-1:0] vpw;
    logic [V_W-1:0] vbp;
    logic [V_W-1:0] vfp;
    logic [V_W-1:0] vact;
  } lcd_cfg_t;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } lcd_out_t;

  // last dot index of a line
  function automatic logic [PIX_W-1:0] lcd_pix_last(lcd_cfg_t c);
    return PIX_W'(c.hpw) + PIX_W'(c.hbp) + PIX_W'(c.hact) + PIX_W'(c.hfp)
         + (PIX_W'(c.dly) << 1) + PIX_W'(4);
  endfunction

  // last line index of a frame
  function automatic logic [LIN_W-1:0] lcd_line_last(lcd_cfg_t c);
    return c.stn ? LIN_W'(c.vact)
                 : LIN_W'(c.vbp) + LIN_W'(c.vact) + LIN_W'(c.vfp);
  endfunction

  // sync / enable levels for one raster position
  function automatic lcd_out_t lcd_decode(lcd_cfg_t c, logic [PIX_W-1:0] pix,
                                          logic [LIN_W-1:0] line);
    logic [PIX_W-1:0] a0;
    logic [LIN_W-1:0] first_ln;
    logic             vis_line;
    lcd_out_t         o;
    a0       = PIX_W'(c.hpw) + PIX_W'(c.hbp) + PIX_W'(c.dly) + PIX_W'(2);
    first_ln = c.stn ? '0 : LIN_W'(c.vbp);
    vis_line = (line >= first_ln) && (line <= first_ln + LIN_W'(c.vact));
    o.hs = (pix <= PIX_W'(c.hpw));
    o.de = vis_line && (pix >= a0) && (pix <= a0 + PIX_W'(c.hact));
    if (c.stn)
      o.vs = ((line == LIN_W'(0)) && (pix >= a0)) || ((line == LIN_W'(1)) && (pix < a0));
    else
      o.vs = (line <= LIN_W'(c.vpw));
    return o;
  endfunction
endpackage

// File: rtl/lcd_dot_div.sv
module lcd_dot_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             dot_ce
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dot_ce <= 1'b0;
    end else if (cnt >= div) begin
      cnt    <= '0;
      dot_ce <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      dot_ce <= 1'b0;
    end
  end

  // a pulse is never followed at once by another unless the divider is 0
  assert_ce_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (dot_ce && div != '0) |=> !dot_ce);
endmodule

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow
  import lcd_sync_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  lcd_cfg_t cfg_in,
  output lcd_cfg_t cfg_q,
  output lcd_cfg_t cfg_nx
);
  assign cfg_nx = (rst || load) ? cfg_in : cfg_q;

  always_ff @(posedge clk) cfg_q <= cfg_nx;

  // shadow only moves at a frame boundary
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/lcd_pos_ctr.sv
module lcd_pos_ctr
  import lcd_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [PIX_W-1:0] pix_last,
  input  logic [LIN_W-1:0] line_last,
  output logic [PIX_W-1:0] pix,
  output logic [LIN_W-1:0] line,
  output logic [PIX_W-1:0] pix_nx,
  output logic [LIN_W-1:0] line_nx,
  output logic             wrap
);
  always_comb begin
    pix_nx  = pix;
    line_nx = line;
    wrap    = 1'b0;
    if (rst) begin
      pix_nx  = '0;
      line_nx = '0;
    end else if (ce) begin
      if (pix >= pix_last) begin
        pix_nx = '0;
        if (line >= line_last) begin
          line_nx = '0;
          wrap    = 1'b1;
        end else begin
          line_nx = line + 1'b1;
        end
      end else begin
        pix_nx = pix + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    pix  <= pix_nx;
    line <= line_nx;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(pix) && $stable(line)));
  assert_pix_range_R3: assert property (@(posedge clk) disable iff (rst)
    pix <= pix_last);
  assert_line_range_R6: assert property (@(posedge clk) disable iff (rst)
    line <= line_last);
endmodule

// File: rtl/lcd_sync_out.sv
module lcd_sync_out
  import lcd_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  lcd_cfg_t         cfg_nx,
  input  logic [PIX_W-1:0] pix_nx,
  input  logic [LIN_W-1:0] line_nx,
  output logic             hsync,
  output logic             vsync,
  output logic             den
);
  lcd_out_t dec;

  // decode the position the counters move to, so outputs line up with them
  always_comb begin
    if (rst) dec = lcd_decode(cfg_nx, '0, '0);
    else     dec = lcd_decode(cfg_nx, pix_nx, line_nx);
  end

  always_ff @(posedge clk) begin
    hsync <= dec.hs;
    vsync <= dec.vs;
    den   <= dec.de;
  end

  assert_den_vs_hsync_R5: assert property (@(posedge clk) disable iff (rst)
    den |-> !hsync);
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stn_mode,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [H_W-1:0]   hsync_width,
  input  logic [H_W-1:0]   hback,
  input  logic [H_W-1:0]   hfront,
  input  logic [H_W-1:0]   sync_delay,
  input  logic [H_W-1:0]   hactive,
  input  logic [V_W-1:0]   vsync_width,
  input  logic [V_W-1:0]   vback,
  input  logic [V_W-1:0]   vfront,
  input  logic [V_W-1:0]   vactive,
  output logic             dot_ce,
  output logic             hsync,
  output logic             vsync,
  output logic             den,
  output logic [PIX_W-1:0] pix_cnt,
  output logic [LIN_W-1:0] line_cnt
);
  lcd_cfg_t         cfg_in, cfg_q, cfg_nx;
  logic [PIX_W-1:0] pix_nx;
  logic [LIN_W-1:0] line_nx;
  logic             wrap;

  assign cfg_in = '{stn: stn_mode, hpw: hsync_width, hbp: hback, hfp: hfront,
                    dly: sync_delay, hact: hactive, vpw: vsync_width,
                    vbp: vback, vfp: vfront, vact: vactive};

  lcd_dot_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(clk_div), .dot_ce(dot_ce)
  );

  lcd_cfg_shadow u_shadow (
    .clk(clk), .rst(rst), .load(wrap), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .cfg_nx(cfg_nx)
  );

  lcd_pos_ctr u_pos (
    .clk(clk), .rst(rst), .ce(dot_ce),
    .pix_last(lcd_pix_last(cfg_q)), .line_last(lcd_line_last(cfg_q)),
    .pix(pix_cnt), .line(line_cnt), .pix_nx(pix_nx), .line_nx(line_nx),
    .wrap(wrap)
  );

  lcd_sync_out u_out (
    .clk(clk), .rst(rst), .cfg_nx(cfg_nx), .pix_nx(pix_nx), .line_nx(line_nx),
    .hsync(hsync), .vsync(vsync), .den(den)
  );

  assert_hs_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (pix_cnt == '0));
  assert_tft_vs_start_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsync) && !cfg_q.stn) |-> (pix_cnt == '0 && line_cnt == '0));
  assert_stn_vs_start_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(vsync) && cfg_q.stn) |-> (den && line_cnt == '0));
endmodule

// File: tb/lcd_sync_gen_tb.sv
module lcd_sync_gen_tb;
  import lcd_sync_pkg::*;

  typedef struct {
    int stn, hpw, hbp, hfp, dly, hact, vpw, vbp, vfp, vact, div;
  } tcfg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  tcfg_t cur, pend, shad;
  int checks = 0, fails = 0;

  logic             dot_ce, hsync, vsync, den;
  logic [PIX_W-1:0] pix_cnt;
  logic [LIN_W-1:0] line_cnt;

  lcd_sync_gen #(.DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .stn_mode(cur.stn[0]), .clk_div(cur.div[7:0]),
    .hsync_width(cur.hpw[H_W-1:0]), .hback(cur.hbp[H_W-1:0]),
    .hfront(cur.hfp[H_W-1:0]), .sync_delay(cur.dly[H_W-1:0]),
    .hactive(cur.hact[H_W-1:0]), .vsync_width(cur.vpw[V_W-1:0]),
    .vback(cur.vbp[V_W-1:0]), .vfront(cur.vfp[V_W-1:0]),
    .vactive(cur.vact[V_W-1:0]),
    .dot_ce(dot_ce), .hsync(hsync), .vsync(vsync), .den(den),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  // model state and run statistics
  int m_pix, m_line;
  int mm_pos, mm_hs, mm_vs, mm_de, mm_gap, mm_hold;
  int n_de, n_hs, n_vs, rise0, rise1, first_ce, last_ce;

  function automatic tcfg_t mk(int stn, int hpw, int hbp, int hfp, int dly,
                               int hact, int vpw, int vbp, int vfp, int vact, int div);
    tcfg_t c;
    c.stn = stn; c.hpw = hpw; c.hbp = hbp; c.hfp = hfp; c.dly = dly;
    c.hact = hact; c.vpw = vpw; c.vbp = vbp; c.vfp = vfp; c.vact = vact; c.div = div;
    return c;
  endfunction

  function automatic int line_len(tcfg_t c);  // R3
    return c.hpw + c.hbp + c.hact + c.hfp + 2 * c.dly + 5;
  endfunction

  function automatic int frame_lines(tcfg_t c);  // R6, R8
    return c.stn ? c.vact + 1 : c.vbp + c.vact + 1 + c.vfp;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(tcfg_t c);
    cur = c;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    m_pix = 0; m_line = 0; shad = c;
    rst = 1'b0;
  endtask

  task automatic run(int ticks, int chg_at);
    int tick = 0, cyc = 0;
    bit prev_vs, e_hs, e_vs, e_de;
    int a0, fl;
    mm_pos = 0; mm_hs = 0; mm_vs = 0; mm_de = 0; mm_gap = 0; mm_hold = 0;
    n_de = 0; n_hs = 0; n_vs = 0; rise0 = -1; rise1 = -1;
    first_ce = -1; last_ce = -1;
    prev_vs = vsync;
    while (tick < ticks) begin
      @(negedge clk);
      cyc++;
      if (!dot_ce) begin
        if (int'(pix_cnt) != m_pix || int'(line_cnt) != m_line) mm_hold++;
      end else begin
        if (tick == chg_at) cur = pend;
        if (last_ce >= 0 && cyc - last_ce != cur.div + 1) mm_gap++;
        if (first_ce < 0) first_ce = cyc;
        last_ce = cyc;
        // expected levels from the requirements
        a0 = shad.hpw + shad.hbp + shad.dly + 2;
        fl = shad.stn ? 0 : shad.vbp;
        e_hs = (m_pix <= shad.hpw);
        e_de = (m_line >= fl) && (m_line <= fl + shad.vact) &&
               (m_pix >= a0) && (m_pix <= a0 + shad.hact);
        e_vs = shad.stn ? ((m_line == 0 && m_pix >= a0) || (m_line == 1 && m_pix < a0))
                        : (m_line <= shad.vpw);
        if (int'(pix_cnt) != m_pix || int'(line_cnt) != m_line) mm_pos++;
        if (hsync != e_hs) mm_hs++;
        if (vsync != e_vs) mm_vs++;
        if (den != e_de) mm_de++;
        if (den) n_de++;
        if (hsync) n_hs++;
        if (vsync) n_vs++;
        if (vsync && !prev_vs) begin
          if (rise0 < 0) rise0 = tick;
          else if (rise1 < 0) rise1 = tick;
        end
        prev_vs = vsync;
        // advance model; fields are taken at the frame boundary (R10)
        if (m_pix == line_len(shad) - 1) begin
          m_pix = 0;
          if (m_line == frame_lines(shad) - 1) begin
            m_line = 0;
            shad = cur;
          end else m_line++;
        end else m_pix++;
        tick++;
      end
    end
  endtask

  task automatic t_reset;
    do_reset(mk(0, 1, 2, 1, 1, 3, 1, 2, 1, 2, 1));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(pix_cnt == '0 && line_cnt == '0, "R1", "counters in reset", int'(pix_cnt) + int'(line_cnt), 0);
    chk(dot_ce == 1'b0 && den == 1'b0, "R1", "dot_ce/den in reset", int'(dot_ce) + int'(den), 0);
    chk(hsync == 1'b1 && vsync == 1'b1, "R1", "TFT hsync+vsync in reset", int'(hsync) + int'(vsync), 2);
    cur.stn = 1;
    repeat (2) @(negedge clk);
    chk(hsync == 1'b1 && vsync == 1'b0, "R1", "STN hsync/vsync in reset", int'(vsync), 0);
  endtask

  task automatic t_tft;
    // line 14 ticks, frame 6 lines = 84 ticks
    do_reset(mk(0, 1, 2, 1, 1, 3, 1, 2, 1, 2, 1));
    run(252, -1);
    chk(mm_pos == 0, "R3", "TFT position mismatches", mm_pos, 0);
    chk(mm_hs == 0 && n_hs == 36, "R4", "TFT hsync ticks", n_hs, 36);
    chk(mm_de == 0 && n_de == 36, "R5", "TFT den ticks", n_de, 36);
    chk(mm_vs == 0 && n_vs == 84, "R7", "TFT vsync ticks", n_vs, 84);
    chk(rise0 == 84 && rise1 - rise0 == 84, "R6", "TFT frame period", rise1 - rise0, 84);
    chk(mm_gap == 0 && mm_hold == 0, "R2", "TFT enable spacing/hold", mm_gap + mm_hold, 0);
  endtask

  task automatic t_stn;
    // vbp/vfp/vpw set but ignored; line 16 ticks, 4 lines = 64 ticks
    do_reset(mk(1, 2, 1, 0, 2, 4, 3, 5, 4, 3, 0));
    run(192, -1);
    chk(mm_pos == 0, "R8", "STN position mismatches", mm_pos, 0);
    chk(mm_de == 0 && n_de == 60, "R8", "STN den ticks (all lines visible)", n_de, 60);
    chk(rise1 - rise0 == 64, "R8", "STN frame period", rise1 - rise0, 64);
    chk(rise0 == 7, "R9", "STN vsync rise tick", rise0, 7);
    chk(mm_vs == 0 && n_vs == 48, "R9", "STN vsync ticks", n_vs, 48);
    chk(mm_gap == 0 && mm_hold == 0, "R2", "divide-by-1 spacing/hold", mm_gap + mm_hold, 0);
  endtask

  task automatic t_min;
    // smallest legal fields: line 6 ticks, frame 2 lines
    do_reset(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 2));
    run(48, -1);
    chk(mm_pos == 0, "R3", "minimum position mismatches", mm_pos, 0);
    chk(mm_hs == 0 && n_hs == 8, "R4", "minimum hsync ticks", n_hs, 8);
    chk(mm_de == 0 && n_de == 16, "R5", "minimum den ticks", n_de, 16);
    chk(mm_vs == 0 && n_vs == 24, "R7", "minimum vsync ticks", n_vs, 24);
    chk(rise1 - rise0 == 12, "R6", "minimum frame period", rise1 - rise0, 12);
  endtask

  task automatic t_shadow;
    // mid-frame rewrite: frame 0 stays 84 ticks, next frames 96
    do_reset(mk(0, 1, 2, 1, 1, 3, 1, 2, 1, 2, 1));
    pend = mk(0, 1, 2, 1, 1, 5, 0, 2, 1, 2, 1);
    run(276, 30);
    chk(rise0 == 84, "R10", "old frame length kept", rise0, 84);
    chk(rise1 == 180, "R10", "new frame length applied", rise1, 180);
    chk(mm_pos + mm_hs + mm_vs + mm_de == 0, "R10", "levels across rewrite",
        mm_pos + mm_hs + mm_vs + mm_de, 0);
  endtask

  task automatic t_div;
    do_reset(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 3));
    run(24, -1);
    chk(last_ce - first_ce == 92, "R2", "24 pulses over divide-by-4", last_ce - first_ce, 92);
    chk(mm_gap == 0, "R2", "pulse gaps", mm_gap, 0);
    chk(mm_hold == 0, "R2", "no change between pulses", mm_hold, 0);
  endtask

  initial begin
    cur = mk(0, 1, 2, 1, 1, 3, 1, 2, 1, 2, 1);
    pend = cur;
    t_reset();
    t_tft();
    t_stn();
    t_min();
    t_shadow();
    t_div();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule